// File: doc/BRIEF.md
# Per-Node Two-Candidate Route Lookup

This block is the routing stage of one router in a small two-dimensional mesh. It keeps a single row of next-hop information: for every destination in the mesh there is one entry naming the output port a packet should take from this node. The entry lists one or two candidate ports chosen from north, south, east, west and the local exit. When an entry lists two candidates, the block picks one of them with a pseudo-random bit, which spreads traffic across both minimal paths.

Lookups travel over a valid/ready request channel and come back one cycle later on a valid/ready response channel. A response that the consumer does not take stays on the outputs unchanged. While it waits, no new request is accepted. A plain write port lets software replace any entry at run time, for example to route around a faulty link or to load a different route set. Out of reset the row holds a west-first route set for the node's position in the mesh.

Destination numbers are `y * MESH_W + x`. North is the direction of increasing y, east is the direction of increasing x. Port codes are exit = 0, N = 1, S = 2, E = 3, W = 4.

Top module: `node_route_table`

## Requirements
- R1: While reset is held and in the first cycle after it, `rsp_valid` is 0 and `req_ready` is 1.
- R2: A request is accepted on a clock edge where `req_valid` and `req_ready` are both 1. On the next cycle `rsp_valid` is 1 and `rsp_port` carries the port chosen for `req_dest`.
- R3: While `rsp_valid` is 1 and `rsp_ready` is 0, `req_ready` is 0 and `rsp_port` does not change. When `rsp_ready` and `req_valid` are both 1 in the same cycle, the old response is consumed and the new request is accepted on the same edge.
- R4: After reset, a lookup of this node's own number returns the exit code 0.
- R5: After reset, a lookup of any destination in a column west of this node returns W (4) on every lookup.
- R6: After reset, a destination in this node's column returns N (1) when it lies north and S (2) when it lies south. A destination in this node's row to the east returns E (3).
- R7: After reset, a destination to the north-east returns E (3) or N (1), and a destination to the south-east returns E (3) or S (2). Over repeated lookups both candidates appear and no other code appears.
- R8: A write with `wr_en` = 1 replaces the entry for `wr_dest`. Port A is always a candidate. Port B is a candidate only when `wr_b_valid` = 1. Later lookups return only the written candidates.
- R9: A lookup accepted on the same edge as a write to the same entry returns the entry's old contents. The next lookup returns the new contents.
- R10: A lookup of a destination number of MESH_W*MESH_H or above returns the exit code 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Lookup request present |
| req_ready | output | 1 | Block can accept a lookup this cycle |
| req_dest | input | DW | Destination number to look up |
| rsp_valid | output | 1 | Lookup result present |
| rsp_ready | input | 1 | Consumer takes the result this cycle |
| rsp_port | output | 3 | Chosen output port code |
| wr_en | input | 1 | Replace one entry this cycle |
| wr_dest | input | DW | Entry to replace |
| wr_port_a | input | 3 | First candidate port code |
| wr_port_b | input | 3 | Second candidate port code |
| wr_b_valid | input | 1 | Second candidate is in use |

## Verification
The bench repeats lookups of the north-east and south-east entries many times. A selector with a stuck or unused random bit would show only one candidate, and a wrong slot decode would let a foreign port code appear. It holds the response under back-pressure while a new request waits. A design that drops ready late would overwrite the pending port, and one that skips the combined consume-and-accept edge would lose a cycle or a request. It issues a write and a lookup of the same entry on the same edge. A design that bypasses the write data into the read would return the new port one lookup too early. It also looks up an unused destination number, which a design that indexes the table without a range check would map onto a real entry.

// File: rtl/rt_pkg.sv
package rt_pkg;

  typedef enum logic [2:0] {
    PORT_EXIT = 3'd0,
    PORT_N    = 3'd1,
    PORT_S    = 3'd2,
    PORT_E    = 3'd3,
    PORT_W    = 3'd4
  } port_e;

  typedef struct packed {
    port_e a;
    port_e b;
    logic  b_vld;
  } rt_entry_t;

  localparam rt_entry_t EXIT_ENTRY = '{a: PORT_EXIT, b: PORT_EXIT, b_vld: 1'b0};

  // West-first next hop from (sx,sy) toward (dx,dy).
  function automatic rt_entry_t wf_entry(int dx, int dy, int sx, int sy);
    rt_entry_t e;
    e = EXIT_ENTRY;
    if (dx < sx) begin
      e.a = PORT_W;
    end else if (dx == sx) begin
      if (dy > sy)      e.a = PORT_N;
      else if (dy < sy) e.a = PORT_S;
    end else begin
      e.a = PORT_E;
      if (dy > sy) begin
        e.b     = PORT_N;
        e.b_vld = 1'b1;
      end else if (dy < sy) begin
        e.b     = PORT_S;
        e.b_vld = 1'b1;
      end
    end
    return e;
  endfunction

endpackage

// File: rtl/rt_lfsr.sv
module rt_lfsr #(
  parameter int          WIDTH = 16,
  parameter logic [15:0] SEED  = 16'hACE1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic step,
  output logic rnd_bit
);
  logic [WIDTH-1:0] state;
  logic             fb;

  generate
    if (WIDTH == 16) begin : g_w16
      assign fb = state[15] ^ state[13] ^ state[12] ^ state[10];
    end else begin : g_wx
      assign fb = state[WIDTH-1] ^ state[WIDTH-2];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n)    state <= WIDTH'(SEED);
    else if (step) state <= {state[WIDTH-2:0], fb};
  end

  assign rnd_bit = state[0];
endmodule

// File: rtl/rt_table.sv
module rt_table
  import rt_pkg::*;
#(
  parameter int MESH_W = 3,
  parameter int MESH_H = 3,
  parameter int NODE_X = 1,
  parameter int NODE_Y = 1,
  localparam int NODES = MESH_W * MESH_H,
  localparam int DW    = (NODES > 1) ? $clog2(NODES) : 1
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      wr_en,
  input  logic [DW-1:0] wr_idx,
  input  rt_entry_t wr_ent,
  input  logic [DW-1:0] rd_idx,
  output rt_entry_t rd_ent
);
  rt_entry_t tbl [NODES];

  generate
    for (genvar g = 0; g < NODES; g++) begin : g_ent
      localparam rt_entry_t RST = wf_entry(g % MESH_W, g / MESH_W, NODE_X, NODE_Y);
      always_ff @(posedge clk) begin
        if (!rst_n)                          tbl[g] <= RST;
        else if (wr_en && wr_idx == DW'(g))  tbl[g] <= wr_ent;
      end
    end
  endgenerate

  // Out-of-range numbers fall through to the exit entry.
  always_comb begin
    rd_ent = EXIT_ENTRY;
    for (int i = 0; i < NODES; i++) begin
      if (rd_idx == DW'(i)) rd_ent = tbl[i];
    end
  end
endmodule

// File: rtl/rt_select.sv
module rt_select
  import rt_pkg::*;
(
  input  rt_entry_t ent,
  input  logic      rnd_bit,
  output port_e     port
);
  always_comb begin
    if (ent.b_vld && rnd_bit) port = ent.b;
    else                      port = ent.a;
  end
endmodule

// File: rtl/node_route_table.sv
module node_route_table
  import rt_pkg::*;
#(
  parameter int          MESH_W    = 3,
  parameter int          MESH_H    = 3,
  parameter int          NODE_X    = 1,
  parameter int          NODE_Y    = 1,
  parameter int          LFSR_W    = 16,
  parameter logic [15:0] LFSR_SEED = 16'hACE1,
  localparam int NODES = MESH_W * MESH_H,
  localparam int DW    = (NODES > 1) ? $clog2(NODES) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [DW-1:0] req_dest,
  output logic          rsp_valid,
  input  logic          rsp_ready,
  output logic [2:0]    rsp_port,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_dest,
  input  logic [2:0]    wr_port_a,
  input  logic [2:0]    wr_port_b,
  input  logic          wr_b_valid
);
  rt_entry_t wr_ent, rd_ent;
  port_e     sel_port;
  logic      rnd_bit;
  logic      accept;
  logic [2:0] cand_a, cand_b;
  logic       cand_b_vld;

  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;

  assign wr_ent.a     = port_e'(wr_port_a);
  assign wr_ent.b     = port_e'(wr_port_b);
  assign wr_ent.b_vld = wr_b_valid;

  rt_table #(
    .MESH_W(MESH_W), .MESH_H(MESH_H), .NODE_X(NODE_X), .NODE_Y(NODE_Y)
  ) u_table (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_idx(wr_dest), .wr_ent(wr_ent),
    .rd_idx(req_dest), .rd_ent(rd_ent)
  );

  rt_lfsr #(.WIDTH(LFSR_W), .SEED(LFSR_SEED)) u_lfsr (
    .clk(clk), .rst_n(rst_n), .step(accept), .rnd_bit(rnd_bit)
  );

  rt_select u_sel (.ent(rd_ent), .rnd_bit(rnd_bit), .port(sel_port));

  assign cand_a     = rd_ent.a;
  assign cand_b     = rd_ent.b;
  assign cand_b_vld = rd_ent.b_vld;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_port  <= PORT_EXIT;
    end else if (accept) begin
      rsp_valid <= 1'b1;
      rsp_port  <= sel_port;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/rt_checker.sv
module rt_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic       req_ready,
  input logic       rsp_valid,
  input logic       rsp_ready,
  input logic [2:0] rsp_port,
  input logic [2:0] cand_a,
  input logic [2:0] cand_b,
  input logic       cand_b_vld
);
  logic past_rst;
  always_ff @(posedge clk) past_rst <= rst_n;

  assert_idle_after_reset_R1: assert property (@(posedge clk)
    disable iff (!rst_n) !past_rst |-> (!rsp_valid && req_ready));

  assert_accept_gives_rsp_R2: assert property (@(posedge clk)
    disable iff (!rst_n) (req_valid && req_ready) |=> rsp_valid);

  assert_hold_stable_R3: assert property (@(posedge clk)
    disable iff (!rst_n) (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_port)));

  assert_stall_blocks_R3: assert property (@(posedge clk)
    disable iff (!rst_n) (rsp_valid && !rsp_ready) |-> !req_ready);

  assert_port_in_entry_R7: assert property (@(posedge clk)
    disable iff (!rst_n) (req_valid && req_ready) |=>
      (rsp_port == $past(cand_a) || ($past(cand_b_vld) && rsp_port == $past(cand_b))));
endmodule

bind node_route_table rt_checker u_chk (
  .clk(clk), .rst_n(rst_n),
  .req_valid(req_valid), .req_ready(req_ready),
  .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_port(rsp_port),
  .cand_a(cand_a), .cand_b(cand_b), .cand_b_vld(cand_b_vld)
);

// File: tb/sim_node_route_table.sv
module sim_node_route_table;
  localparam int DW = 4;
  localparam logic [2:0] P_X = 3'd0, P_N = 3'd1, P_S = 3'd2, P_E = 3'd3, P_W = 3'd4;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, req_valid, req_ready, rsp_valid, rsp_ready;
  logic wr_en, wr_b_valid;
  logic [DW-1:0] req_dest, wr_dest;
  logic [2:0] rsp_port, wr_port_a, wr_port_b;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  node_route_table u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_dest(req_dest), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_port(rsp_port), .wr_en(wr_en), .wr_dest(wr_dest),
    .wr_port_a(wr_port_a), .wr_port_b(wr_port_b), .wr_b_valid(wr_b_valid)
  );

  task automatic check(input bit ok, input string rq, input int got, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", rq, got, exp);
    end
  endtask

  task automatic lookup(input logic [DW-1:0] d, output logic [2:0] p, output logic v);
    @(negedge clk); req_valid = 1; req_dest = d; rsp_ready = 1;
    @(negedge clk); req_valid = 0; p = rsp_port; v = rsp_valid;
  endtask

  task automatic write_ent(input logic [DW-1:0] d, input logic [2:0] a,
                           input logic [2:0] b, input logic bv);
    @(negedge clk); wr_en = 1; wr_dest = d; wr_port_a = a; wr_port_b = b; wr_b_valid = bv;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic t_reset;
    check(rsp_valid == 0, "R1 rsp_valid after reset", int'(rsp_valid), 0);
    check(req_ready == 1, "R1 req_ready after reset", int'(req_ready), 1);
  endtask

  task automatic t_single(input logic [DW-1:0] d, input logic [2:0] exp, input string rq);
    logic [2:0] p; logic v;
    for (int k = 0; k < 3; k++) begin
      lookup(d, p, v);
      check(v == 1, "R2 rsp_valid one cycle after accept", int'(v), 1);
      check(p == exp, rq, int'(p), int'(exp));
    end
  endtask

  task automatic t_pair(input logic [DW-1:0] d, input logic [2:0] c0,
                        input logic [2:0] c1, input string rq);
    logic [2:0] p; logic v;
    int n0 = 0, n1 = 0, nx = 0;
    for (int k = 0; k < 40; k++) begin
      lookup(d, p, v);
      if (p == c0) n0++;
      else if (p == c1) n1++;
      else begin nx++; check(0, {rq, " foreign port"}, int'(p), int'(c0)); end
    end
    check(n0 > 0, {rq, " first candidate seen"}, n0, 1);
    check(n1 > 0, {rq, " second candidate seen"}, n1, 1);
    check(nx == 0, {rq, " no foreign port"}, nx, 0);
  endtask

  task automatic t_backpressure;
    logic [2:0] held;
    @(negedge clk); req_valid = 1; req_dest = 4'd4; rsp_ready = 0;
    @(negedge clk); req_dest = 4'd0;  // new request waits
    check(rsp_valid == 1, "R3 response pending", int'(rsp_valid), 1);
    check(req_ready == 0, "R3 ready low under stall", int'(req_ready), 0);
    held = rsp_port;
    check(held == P_X, "R4 own node gives exit", int'(held), int'(P_X));
    repeat (3) @(negedge clk);
    check(rsp_port == held && rsp_valid, "R3 response held", int'(rsp_port), int'(held));
    rsp_ready = 1;  // consume and accept on the same edge
    @(negedge clk); req_valid = 0;
    check(rsp_valid == 1, "R3 back-to-back accept", int'(rsp_valid), 1);
    check(rsp_port == P_W, "R3 waiting request served", int'(rsp_port), int'(P_W));
    @(negedge clk);
    check(rsp_valid == 0, "R3 drained", int'(rsp_valid), 0);
  endtask

  task automatic t_write;
    logic [2:0] p; logic v;
    write_ent(4'd0, P_E, P_X, 1'b0);
    lookup(4'd0, p, v);
    check(p == P_E, "R8 single rewritten entry", int'(p), int'(P_E));
    write_ent(4'd8, P_S, P_W, 1'b1);
    t_pair(4'd8, P_S, P_W, "R8 rewritten pair");
  endtask

  task automatic t_same_cycle;
    logic [2:0] p; logic v;
    @(negedge clk);
    wr_en = 1; wr_dest = 4'd5; wr_port_a = P_N; wr_port_b = P_X; wr_b_valid = 0;
    req_valid = 1; req_dest = 4'd5; rsp_ready = 1;
    @(negedge clk); wr_en = 0; req_valid = 0;
    check(rsp_port == P_E, "R9 old value on colliding lookup", int'(rsp_port), int'(P_E));
    lookup(4'd5, p, v);
    check(p == P_N, "R9 new value next lookup", int'(p), int'(P_N));
  endtask

  initial begin
    rst_n = 0; req_valid = 0; rsp_ready = 1; req_dest = 0;
    wr_en = 0; wr_dest = 0; wr_port_a = 0; wr_port_b = 0; wr_b_valid = 0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_reset();
    // node at (1,1); dest = y*3 + x
    t_single(4'd4, P_X, "R4 own node exit");
    t_single(4'd0, P_W, "R5 south-west gives W");
    t_single(4'd3, P_W, "R5 west gives W");
    t_single(4'd6, P_W, "R5 north-west gives W");
    t_single(4'd7, P_N, "R6 north gives N");
    t_single(4'd1, P_S, "R6 south gives S");
    t_single(4'd5, P_E, "R6 east gives E");
    t_pair(4'd8, P_E, P_N, "R7 north-east");
    t_pair(4'd2, P_E, P_S, "R7 south-east");
    t_single(4'd12, P_X, "R10 out-of-range gives exit");
    t_backpressure();
    t_same_cycle();
    t_write();
    done = 1;
  end

  initial begin
    for (int c = 0; c < 20000 && !done; c++) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got %0d expected %0d", 0, 1);
    end
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule